// File: doc/BRIEF.md
# Test Packet Generator Sequencer

This block is a built-in stimulus source for a serial block encoder under test. It shifts out a pseudo-random message packet one bit per enabled tick. It then holds its data output low for exactly as many ticks as the encoder needs to emit the matching checksum, and then starts the next packet at once. The message bits come from a 15-bit maximal-length LFSR that is seeded on reset and keeps running from packet to packet.

Alongside the data the block drives a packet strobe. The strobe is high while message bits are on the wire and low during the checksum interval, so it can be wired straight to the encoder's message/checksum select input. A ready flag tells the consumer when the stream is trustworthy. The flag ignores the first, possibly partial, strobe period and asserts only on the second rising edge of the strobe.

Every counter and the LFSR move only on cycles where the bit-rate enable is high, so the encoder can run at any fraction of the system clock.

Top module: `pktgen_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to its start state. In that state `sel_msg` = 1, `data_ready` = 0, and `msg_bit` equals bit 14 (the MSB) of the `SEED` parameter.
- R2: From the start of a packet, `sel_msg` stays 1 for exactly `MSG_BITS` enabled ticks.
- R3: After a packet, `sel_msg` stays 0 for exactly `CHK_BITS` enabled ticks. The next enabled tick sets it back to 1, and that tick starts a new packet.
- R4: `msg_bit` is 0 on every cycle where `sel_msg` is 0.
- R5: The k-th message bit since reset (k = 0, 1, ...) is the MSB of a 15-bit register. That register starts at `SEED` and is stepped k times. One step shifts left by one and puts bit14 XOR bit13 into bit 0. The sequence carries on across packets without reseeding.
- R6: `data_ready` is 0 from reset through the whole first strobe period. It becomes 1 on the same cycle as the second rising edge of `sel_msg` after reset, which is 2*(`MSG_BITS`+`CHK_BITS`) enabled ticks after reset.
- R7: Once `data_ready` is 1, it stays 1 until the next reset.
- R8: On a cycle where `bit_en` is 0, `msg_bit`, `sel_msg` and `data_ready` keep their values.
- R9: A reset in the middle of a run restarts the packet timing, the LFSR sequence and the ready qualification from the start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable; one tick per serial bit |
| msg_bit | output | 1 | Serial message bit, low during the checksum interval |
| sel_msg | output | 1 | Packet strobe: 1 for message, 0 for checksum interval |
| data_ready | output | 1 | High once the stream is past its first full strobe period |

## Verification
The assertions check some rules on every cycle. They check that outputs hold when the enable is low, that data stays quiet while the strobe is low, and that the ready flag stays set once set and only rises together with a strobe rising edge. They also keep the phase counter inside its bounds and keep the LFSR away from the all-zero state. Other behaviour can only be shown by the bench scenarios, which compare every sampled cycle against an independent tick model. These scenarios confirm the exact packet and gap lengths, the LFSR bit order across packet boundaries, and the tick on which ready first rises. They also show that timing stays correct when the enable has gaps and that a reset in mid-run gives a clean restart.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;

  localparam int LFSR_W = 15;

  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef enum logic {
    PH_CHK = 1'b0,
    PH_MSG = 1'b1
  } phase_t;

  // x^15 + x^14 + 1, shift toward the MSB, feedback enters at bit 0
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction

endpackage

// File: rtl/pktgen_phase.sv
module pktgen_phase
  import pktgen_pkg::*;
#(
  parameter int MSG_BITS = 1784,
  parameter int CHK_BITS = 256
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_en,
  output phase_t phase_q,
  output logic   next_msg,
  output logic   pkt_start
);

  localparam int LONGEST = (MSG_BITS > CHK_BITS) ? MSG_BITS : CHK_BITS;
  localparam int CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [CW-1:0] MSG_LAST = CW'(MSG_BITS - 1);
  localparam logic [CW-1:0] CHK_LAST = CW'(CHK_BITS - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  always_comb begin
    at_end    = (phase_q == PH_MSG) ? (cnt_q == MSG_LAST) : (cnt_q == CHK_LAST);
    next_msg  = at_end ? (phase_q == PH_CHK) : (phase_q == PH_MSG);
    pkt_start = bit_en && at_end && (phase_q == PH_CHK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_MSG;
      cnt_q   <= '0;
    end else if (bit_en) begin
      if (at_end) begin
        phase_q <= (phase_q == PH_MSG) ? PH_CHK : PH_MSG;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the counter never runs past the message length
  p_msg_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MSG) |-> (cnt_q <= MSG_LAST));

  // R3: the counter never runs past the checksum length
  p_chk_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CHK) |-> (cnt_q <= CHK_LAST));

  // R2: the checksum gap is only entered from the last message bit
  p_msg_exit_r2: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_MSG) && bit_en && (cnt_q != MSG_LAST)) |=> (phase_q == PH_MSG));

  // R8: the counter holds without an enable
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(cnt_q));

endmodule

// File: rtl/pktgen_lfsr.sv
module pktgen_lfsr
  import pktgen_pkg::*;
#(
  parameter lfsr_t SEED = 15'h4A5F
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic clr,
  output logic bit_q
);

  lfsr_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= lfsr_step(SEED);
      bit_q   <= SEED[LFSR_W-1];
    end else if (adv) begin
      bit_q   <= state_q[LFSR_W-1];
      state_q <= lfsr_step(state_q);
    end else if (clr) begin
      bit_q <= 1'b0;
    end
  end

  // R5: a maximal-length register must never fall into the all-zero lock
  p_state_live_r5: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R8: the sequence moves only on an advance
  p_state_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state_q));

endmodule

// File: rtl/pktgen_ready.sv
module pktgen_ready (
  input  logic clk,
  input  logic rst,
  input  logic pkt_start,
  output logic ready_q
);

  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (pkt_start) begin
      seen_q <= 1'b1;
      if (seen_q) ready_q <= 1'b1;
    end
  end

  // R7: once qualified, the flag never drops
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);

  // R6: the flag needs a strobe rise already recorded
  p_ready_second_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(seen_q));

endmodule

// File: rtl/pktgen_seq.sv
module pktgen_seq
  import pktgen_pkg::*;
#(
  parameter int    MSG_BITS = 1784,
  parameter int    CHK_BITS = 256,
  parameter lfsr_t SEED     = 15'h4A5F
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic msg_bit,
  output logic sel_msg,
  output logic data_ready
);

  phase_t phase_q;
  logic   next_msg;
  logic   pkt_start;
  logic   adv;
  logic   clr;

  pktgen_phase #(
    .MSG_BITS (MSG_BITS),
    .CHK_BITS (CHK_BITS)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .phase_q   (phase_q),
    .next_msg  (next_msg),
    .pkt_start (pkt_start)
  );

  assign adv = bit_en & next_msg;
  assign clr = bit_en & ~next_msg;

  pktgen_lfsr #(
    .SEED (SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .clr   (clr),
    .bit_q (msg_bit)
  );

  pktgen_ready u_ready (
    .clk       (clk),
    .rst       (rst),
    .pkt_start (pkt_start),
    .ready_q   (data_ready)
  );

  assign sel_msg = (phase_q == PH_MSG);

  // R8: no output moves on an idle cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(msg_bit) && $stable(sel_msg) && $stable(data_ready)));

  // R4: the data line is quiet during the checksum interval
  p_quiet_chk_r4: assert property (@(posedge clk) disable iff (rst)
    !sel_msg |-> !msg_bit);

  // R6: qualification coincides with a strobe rising edge
  p_ready_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $rose(sel_msg));

  // R3: a strobe rise always follows an enabled tick
  p_rise_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_msg) |-> $past(bit_en));

endmodule

// File: tb/pktgen_seq_test.sv
module pktgen_seq_test;

  localparam int          M    = 24;
  localparam int          C    = 8;
  localparam int          P    = M + C;
  localparam logic [14:0] SEED = 15'h4A5F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic msg_bit, sel_msg, data_ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int          t;
  logic [14:0] r;
  logic        prev_msg, prev_sel, prev_rdy;

  always #2.5 clk = ~clk;

  pktgen_seq #(
    .MSG_BITS (M),
    .CHK_BITS (C),
    .SEED     (SEED)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .msg_bit    (msg_bit),
    .sel_msg    (sel_msg),
    .data_ready (data_ready)
  );

  function automatic logic [14:0] ref_step(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, exp);
    end
  endtask

  task automatic check_model();
    int pos;
    pos = t % P;
    if (pos < M) begin
      check("R2 sel high in packet", sel_msg, 1'b1);
      check("R5 lfsr bit", msg_bit, r[14]);
    end else begin
      check("R3 sel low in gap", sel_msg, 1'b0);
      check("R4 quiet data", msg_bit, 1'b0);
    end
    if (t < 2 * P) check("R6 ready held off", data_ready, 1'b0);
    else if (t == 2 * P) check("R6 ready at second rise", data_ready, 1'b1);
    else check("R7 ready sticky", data_ready, 1'b1);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    bit_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t = 0;
    r = SEED;
    check({tag, " R1 sel"}, sel_msg, 1'b1);
    check({tag, " R1 ready"}, data_ready, 1'b0);
    check({tag, " R1 msg"}, msg_bit, SEED[14]);
  endtask

  // one cycle with the given enable; checks at the following negedge
  task automatic step(input logic e);
    prev_msg = msg_bit;
    prev_sel = sel_msg;
    prev_rdy = data_ready;
    bit_en = e;
    @(posedge clk);
    @(negedge clk);
    if (e) begin
      if ((t % P) < M) r = ref_step(r);
      t++;
    end else begin
      check("R8 msg hold", msg_bit, prev_msg);
      check("R8 sel hold", sel_msg, prev_sel);
      check("R8 ready hold", data_ready, prev_rdy);
    end
    check_model();
  endtask

  task automatic scen_continuous();
    do_reset("cont");
    for (int i = 0; i < 3 * P + 5; i++) step(1'b1);
  endtask

  task automatic scen_gapped();
    do_reset("gap");
    for (int i = 0; i < 3 * (2 * P + 4); i++) step((i % 3) != 0);
  endtask

  task automatic scen_midrun_reset();
    do_reset("pre");
    for (int i = 0; i < P + 11; i++) step(1'b1);
    do_reset("R9 midrun");
    for (int i = 0; i < 2 * (2 * P + 3); i++) step((i % 4) != 1);
  endtask

  initial begin
    t = 0;
    r = SEED;
    repeat (3) @(posedge clk);
    scen_continuous();
    scen_gapped();
    scen_midrun_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule